// File: doc/BRIEF.md
# Output Protection and Diagnosis Controller

This block sits between a command decoder and twelve power switches (six high-side, six low-side). It holds the most recent 16-bit command word and combines it with the hardware inhibit pin and the raw fault comparators to produce one enable per switch and one 16-bit status word for readback. The fault comparators report supply overvoltage and undervoltage, per-switch short circuit and open load, and temperature warning and shutdown.

Faults are filtered in time. A free-running prescaler produces a base tick, and every delay is counted in these ticks. A supply supervisor state machine has three states. It moves from `SUP_OK` to `SUP_WAIT` when the supply leaves its window. It returns from `SUP_WAIT` to `SUP_OK` if the supply recovers early. It moves from `SUP_WAIT` to `SUP_FAIL` once the delay expires, and from `SUP_FAIL` back to `SUP_OK` as soon as the supply is normal again. Each switch has its own short-circuit state machine. It moves from `SC_IDLE` to `SC_TIME` while the switch is driven into a short. It returns from `SC_TIME` to `SC_IDLE` if the short clears early or the switch stops being driven. It moves from `SC_TIME` to `SC_TRIP` when its delay expires, and from `SC_TRIP` to `SC_IDLE` only on a status-reset command.

The power-fail, short-circuit and overtemperature indications are sticky. A command word with its reset bit set clears all three. A command delay-select bit picks the long or the short delay for overvoltage and for short circuits. The undervoltage delay is fixed.

Top module: `drv_guard_ctl`

## Requirements
- R1: After reset the held command has bits 15, 14 and 13 high and all other bits low, so all twelve enables are low and the status word reads 0x0000 while no fault input is active.
- R2: A command applied with `cmd_load` takes effect at the next clock edge. Command bit 2k-1 drives low-side switch k and bit 2k drives high-side switch k, for k = 1 to 6, with high meaning on.
- R3: When command bit 15 is low or `wake_pin` is low, all enables are low and status bit 14 reads high. Otherwise status bit 14 reads low.
- R4: While command bit 13 is high, status bit 2k-1 equals the low-side k enable and status bit 2k equals the high-side k enable.
- R5: While command bit 13 is low, the status bit of a switch that is off equals its open-load flag, and the status bit of a switch that is on reads low.
- R6: A supply fault must last `OV_LONG_T` ticks (overvoltage, command bit 14 high), `OV_SHORT_T` ticks (overvoltage, bit 14 low) or `UV_T` ticks (undervoltage only) before it acts. A shorter fault has no effect.
- R7: Once a supply fault has acted, all enables are low and status bit 15 is set. The enables return one cycle after the supply is normal again, but bit 15 stays set until a status reset.
- R8: A short flag held on a driven switch for `SC_LONG_T` ticks (bit 14 high) or `SC_SHORT_T` ticks (bit 14 low) turns that switch off and sets status bit 13. A shorter pulse has no effect. The switch stays off until a status reset, even after the flag drops.
- R9: Applying a command with bit 0 high clears status bits 15 and 13, every short trip and the overtemperature latch at that edge, unless the fault cause is still present.
- R10: A temperature shutdown flag latches: all enables go low and the status word reads 0xFFFF from the next cycle until a status reset.
- R11: Outside overtemperature shutdown, status bit 0 equals the temperature warning flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 16 | Command word |
| cmd_load | input | 1 | Strobe that applies `cmd_word` |
| wake_pin | input | 1 | Hardware inhibit, low = standby |
| hs_short | input | 6 | Short-circuit flags, high-side switches 1..6 |
| ls_short | input | 6 | Short-circuit flags, low-side switches 1..6 |
| hs_open | input | 6 | Open-load flags, high-side switches 1..6 |
| ls_open | input | 6 | Open-load flags, low-side switches 1..6 |
| sup_ov | input | 1 | Supply overvoltage flag |
| sup_uv | input | 1 | Supply undervoltage flag |
| temp_warn | input | 1 | Temperature prewarning flag |
| temp_shut | input | 1 | Temperature shutdown flag |
| hs_en | output | 6 | High-side enables |
| ls_en | output | 6 | Low-side enables |
| status | output | 16 | Status word |

## Verification
The assertions assume that the fault flags are synchronous to `clk` and that `cmd_load` is a single-cycle strobe. They also assume that the temperature shutdown flag does not rise in the same cycle that a status reset is meant to take effect. The stimulus drives every input on the falling clock edge, keeps each strobe to one cycle, and changes only one fault source per scenario. Expected delays are checked with a margin of at least one tick on each side, because the prescaler phase is not visible at the ports.

// File: rtl/drv_guard_pkg.sv
package drv_guard_pkg;

    typedef enum logic [1:0] {
        SUP_OK   = 2'd0,
        SUP_WAIT = 2'd1,
        SUP_FAIL = 2'd2
    } sup_state_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_TIME = 2'd1,
        SC_TRIP = 2'd2
    } sc_state_e;

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == TW'(TICK_DIV - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + TW'(1);
        end
    end

    assign tick = (div_q == TW'(TICK_DIV - 1));

endmodule

// File: rtl/supply_watch.sv
module supply_watch
    import drv_guard_pkg::*;
#(
    parameter int DW         = 8,
    parameter int OV_LONG_T  = 30,
    parameter int OV_SHORT_T = 7,
    parameter int UV_T       = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ov,
    input  logic uv,
    input  logic sel_long,
    output logic fail
);
    sup_state_e    state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] lim;
    logic          fault;

    assign fault = ov | uv;
    assign lim   = ov ? (sel_long ? DW'(OV_LONG_T) : DW'(OV_SHORT_T)) : DW'(UV_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SUP_OK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SUP_OK: begin
                cnt_d = '0;
                if (fault) state_d = SUP_WAIT;
            end
            SUP_WAIT: begin
                if (!fault) begin
                    state_d = SUP_OK;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= lim - DW'(1)) begin
                        state_d = SUP_FAIL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + DW'(1);
                    end
                end
            end
            SUP_FAIL: begin
                cnt_d = '0;
                if (!fault) state_d = SUP_OK;
            end
            default: state_d = SUP_OK;
        endcase
    end

    assign fail = (state_q == SUP_FAIL);

    // R7: outputs come back one cycle after the supply returns to normal
    assert_fail_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_FAIL && !fault) |=> (state_q == SUP_OK));

    // R6: the delay counter never passes the selected limit
    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_WAIT && fault) |-> (cnt_q < lim || lim == '0));

endmodule

// File: rtl/short_guard.sv
module short_guard
    import drv_guard_pkg::*;
#(
    parameter int DW         = 8,
    parameter int SC_LONG_T  = 200,
    parameter int SC_SHORT_T = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic flag,
    input  logic sel_long,
    input  logic clr,
    output logic en,
    output logic tripped
);
    sc_state_e     state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] lim;

    assign lim = sel_long ? DW'(SC_LONG_T) : DW'(SC_SHORT_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SC_IDLE: begin
                cnt_d = '0;
                if (armed && flag) state_d = SC_TIME;
            end
            SC_TIME: begin
                if (!armed || !flag) begin
                    state_d = SC_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= lim - DW'(1)) begin
                        state_d = SC_TRIP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + DW'(1);
                    end
                end
            end
            SC_TRIP: begin
                cnt_d = '0;
                if (clr) state_d = SC_IDLE;
            end
            default: state_d = SC_IDLE;
        endcase
    end

    assign tripped = (state_q == SC_TRIP);
    assign en      = armed && (state_q != SC_TRIP);

    // R8: a tripped switch stays tripped until a status reset
    assert_trip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_TRIP && !clr) |=> (state_q == SC_TRIP));

    // R8: no trip without the short flag having been present while driven
    assert_trip_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SC_TRIP && state_d == SC_TRIP) |-> (armed && flag));

endmodule

// File: rtl/drv_guard_ctl.sv
module drv_guard_ctl #(
    parameter int NOUT       = 6,
    parameter int TICK_DIV   = 50000,
    parameter int OV_LONG_T  = 30,
    parameter int OV_SHORT_T = 7,
    parameter int UV_T       = 20,
    parameter int SC_LONG_T  = 200,
    parameter int SC_SHORT_T = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NOUT+3:0]   cmd_word,
    input  logic                cmd_load,
    input  logic                wake_pin,
    input  logic [NOUT-1:0]     hs_short,
    input  logic [NOUT-1:0]     ls_short,
    input  logic [NOUT-1:0]     hs_open,
    input  logic [NOUT-1:0]     ls_open,
    input  logic                sup_ov,
    input  logic                sup_uv,
    input  logic                temp_warn,
    input  logic                temp_shut,
    output logic [NOUT-1:0]     hs_en,
    output logic [NOUT-1:0]     ls_en,
    output logic [2*NOUT+3:0]   status
);
    localparam int CW      = 2 * NOUT + 4;
    localparam int B_CLR   = 0;
    localparam int B_OLOFF = CW - 3;
    localparam int B_LONG  = CW - 2;
    localparam int B_RUN   = CW - 1;
    localparam int B_SCD   = CW - 3;
    localparam int B_STBY  = CW - 2;
    localparam int B_PSF   = CW - 1;
    localparam int MAX_A   = (OV_LONG_T > OV_SHORT_T) ? OV_LONG_T : OV_SHORT_T;
    localparam int MAX_B   = (SC_LONG_T > SC_SHORT_T) ? SC_LONG_T : SC_SHORT_T;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T   = (MAX_C > UV_T) ? MAX_C : UV_T;
    localparam int DW      = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] CMD_RST = {3'b111, {(CW-3){1'b0}}};

    logic [CW-1:0]   cmd_q;
    logic            tick;
    logic            sup_fail;
    logic            psf_q, scd_q, ot_q;
    logic            srr;
    logic            stby;
    logic            block;
    logic [NOUT-1:0] hs_trip, ls_trip;
    logic            any_trip;

    assign srr = cmd_load & cmd_word[B_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_RST;
            psf_q <= 1'b0;
            scd_q <= 1'b0;
            ot_q  <= 1'b0;
        end else begin
            if (cmd_load) cmd_q <= cmd_word;
            psf_q <= sup_fail | (psf_q & ~srr);
            scd_q <= ~srr & (scd_q | any_trip);
            ot_q  <= temp_shut | (ot_q & ~srr);
        end
    end

    tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    supply_watch #(
        .DW        (DW),
        .OV_LONG_T (OV_LONG_T),
        .OV_SHORT_T(OV_SHORT_T),
        .UV_T      (UV_T)
    ) u_supply (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ov      (sup_ov),
        .uv      (sup_uv),
        .sel_long(cmd_q[B_LONG]),
        .fail    (sup_fail)
    );

    assign stby  = ~cmd_q[B_RUN] | ~wake_pin;
    assign block = stby | sup_fail | ot_q;

    for (genvar k = 0; k < NOUT; k++) begin : g_sw
        short_guard #(
            .DW        (DW),
            .SC_LONG_T (SC_LONG_T),
            .SC_SHORT_T(SC_SHORT_T)
        ) u_ls (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .armed   (cmd_q[2*k+1] & ~block),
            .flag    (ls_short[k]),
            .sel_long(cmd_q[B_LONG]),
            .clr     (srr),
            .en      (ls_en[k]),
            .tripped (ls_trip[k])
        );
        short_guard #(
            .DW        (DW),
            .SC_LONG_T (SC_LONG_T),
            .SC_SHORT_T(SC_SHORT_T)
        ) u_hs (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .armed   (cmd_q[2*k+2] & ~block),
            .flag    (hs_short[k]),
            .sel_long(cmd_q[B_LONG]),
            .clr     (srr),
            .en      (hs_en[k]),
            .tripped (hs_trip[k])
        );
    end

    assign any_trip = |{hs_trip, ls_trip};

    always_comb begin
        status = '0;
        if (ot_q) begin
            status = '1;
        end else begin
            status[0] = temp_warn;
            for (int k = 0; k < NOUT; k++) begin
                if (cmd_q[B_OLOFF]) begin
                    status[2*k+1] = ls_en[k];
                    status[2*k+2] = hs_en[k];
                end else begin
                    status[2*k+1] = ~ls_en[k] & ls_open[k];
                    status[2*k+2] = ~hs_en[k] & hs_open[k];
                end
            end
            status[B_SCD]  = scd_q;
            status[B_STBY] = stby;
            status[B_PSF]  = psf_q;
        end
    end

    // R3: standby forces every switch off
    assert_standby_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_pin || !cmd_q[B_RUN]) |-> (hs_en == '0 && ls_en == '0));

    // R7: the power-fail bit holds without a status reset
    assert_psf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_PSF] && !(cmd_load && cmd_word[B_CLR])) |=> status[B_PSF]);

    // R10: overtemperature shutdown reads as all ones on the next cycle
    assert_ot_all_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        temp_shut |=> (status == '1 && hs_en == '0 && ls_en == '0));

    // R8: the short bit, once set, holds without a status reset
    assert_scd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scd_q && !(cmd_load && cmd_word[B_CLR])) |=> scd_q);

endmodule

// File: tb/drv_guard_ctl_bench.sv
module drv_guard_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_load = 1'b0;
    logic        wake_pin = 1'b1;
    logic [5:0]  hs_short = '0, ls_short = '0, hs_open = '0, ls_open = '0;
    logic        sup_ov = 1'b0, sup_uv = 1'b0, temp_warn = 1'b0, temp_shut = 1'b0;
    logic [5:0]  hs_en, ls_en;
    logic [15:0] status;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    drv_guard_ctl #(
        .NOUT(6), .TICK_DIV(4), .OV_LONG_T(6), .OV_SHORT_T(3),
        .UV_T(4), .SC_LONG_T(8), .SC_SHORT_T(2)
    ) u_drv_guard_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_load(cmd_load),
        .wake_pin(wake_pin), .hs_short(hs_short), .ls_short(ls_short),
        .hs_open(hs_open), .ls_open(ls_open), .sup_ov(sup_ov), .sup_uv(sup_uv),
        .temp_warn(temp_warn), .temp_shut(temp_shut),
        .hs_en(hs_en), .ls_en(ls_en), .status(status)
    );

    // vector table: command, pin, open flags, expected enables and status
    localparam int NV = 6;
    localparam logic [15:0] VCMD [NV] = '{16'hE042, 16'hFFFE, 16'h7FFE, 16'hFFFE, 16'hC004, 16'hC000};
    localparam logic        VPIN [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [5:0]  VHO  [NV] = '{6'h00, 6'h00, 6'h00, 6'h00, 6'h3F, 6'h00};
    localparam logic [5:0]  VLO  [NV] = '{6'h00, 6'h00, 6'h00, 6'h00, 6'h3F, 6'h03};
    localparam logic [5:0]  VHS  [NV] = '{6'h04, 6'h3F, 6'h00, 6'h00, 6'h01, 6'h00};
    localparam logic [5:0]  VLS  [NV] = '{6'h01, 6'h3F, 6'h00, 6'h00, 6'h00, 6'h00};
    localparam logic [15:0] VST  [NV] = '{16'h0042, 16'h1FFE, 16'h4000, 16'h4000, 16'h1FFA, 16'h000A};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] w);
        @(negedge clk);
        cmd_word = w;
        cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset hs_en", {10'd0, hs_en}, 16'h0000);
        chk("R1 reset ls_en", {10'd0, ls_en}, 16'h0000);
        chk("R1 reset status", status, 16'h0000);

        // R2 R3 R4 R5 through the table
        for (int i = 0; i < NV; i++) begin
            hs_open  = VHO[i];
            ls_open  = VLO[i];
            wake_pin = VPIN[i];
            load(VCMD[i]);
            chk($sformatf("R2 R3 hs_en vector %0d", i), {10'd0, hs_en}, {10'd0, VHS[i]});
            chk($sformatf("R2 R3 ls_en vector %0d", i), {10'd0, ls_en}, {10'd0, VLS[i]});
            chk($sformatf("R4 R5 status vector %0d", i), status, VST[i]);
        end
        hs_open  = '0;
        ls_open  = '0;
        wake_pin = 1'b1;

        // R11 warning bit
        load(16'hE002);
        temp_warn = 1'b1;
        idle(1);
        chk("R11 warning bit", status, 16'h0003);
        temp_warn = 1'b0;

        // R6 R7 long overvoltage delay
        sup_ov = 1'b1;
        idle(12);
        chk("R6 ov long not yet", {10'd0, ls_en}, 16'h0001);
        idle(20);
        chk("R7 ov fail outputs", {10'd0, ls_en}, 16'h0000);
        chk("R7 ov fail status", status, 16'h8000);
        sup_ov = 1'b0;
        idle(1);
        chk("R7 recover outputs", {10'd0, ls_en}, 16'h0001);
        chk("R7 psf sticky", status, 16'h8002);
        load(16'hE003);
        chk("R9 psf cleared", status, 16'h0002);

        // R6 short overvoltage delay and a short pulse
        load(16'hA002);
        sup_ov = 1'b1;
        idle(5);
        sup_ov = 1'b0;
        idle(1);
        chk("R6 ov pulse ignored", status, 16'h0002);
        sup_ov = 1'b1;
        idle(20);
        chk("R6 ov short delay", status, 16'h8000);
        sup_ov = 1'b0;
        idle(1);
        load(16'hA003);
        chk("R9 psf cleared again", status, 16'h0002);

        // R6 undervoltage fixed delay
        sup_uv = 1'b1;
        idle(12);
        chk("R6 uv not yet", status, 16'h0002);
        idle(12);
        chk("R6 uv fail", status, 16'h8000);
        sup_uv = 1'b0;
        idle(1);
        load(16'hA003);
        chk("R9 uv cleared", status, 16'h0002);

        // R8 short circuit, short delay
        load(16'hA004);
        chk("R2 hs1 on", {10'd0, hs_en}, 16'h0001);
        hs_short[0] = 1'b1;
        idle(3);
        hs_short[0] = 1'b0;
        idle(1);
        chk("R8 short pulse ignored", status, 16'h0004);
        hs_short[0] = 1'b1;
        idle(14);
        chk("R8 short trip hs_en", {10'd0, hs_en}, 16'h0000);
        chk("R8 short trip status", status, 16'h2000);
        hs_short[0] = 1'b0;
        idle(4);
        chk("R8 trip holds", status, 16'h2000);
        load(16'hA005);
        chk("R9 trip cleared", status, 16'h0004);

        // R8 long short-circuit delay
        load(16'hE004);
        hs_short[0] = 1'b1;
        idle(14);
        chk("R8 long not yet", status, 16'h0004);
        idle(30);
        chk("R8 long trip", status, 16'h2000);
        hs_short[0] = 1'b0;
        load(16'hE005);
        chk("R9 long trip cleared", {10'd0, hs_en}, 16'h0001);

        // R10 overtemperature latch
        temp_shut = 1'b1;
        idle(1);
        temp_shut = 1'b0;
        chk("R10 ot status", status, 16'hFFFF);
        chk("R10 ot outputs", {10'd0, hs_en}, 16'h0000);
        idle(3);
        chk("R10 ot holds", status, 16'hFFFF);
        load(16'hE005);
        chk("R9 ot cleared", status, 16'h0004);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule